// File: doc/BRIEF.md
# Wavefront Issue Arbiter for a Four-SIMD Compute Unit

This block is the issue stage of a compute unit that holds four SIMDs, each hosting up to 24 resident wavefronts. Decode presents one instruction per wavefront, tagged with its instruction class. The arbiter keeps a ready flag and a class tag for every wave slot. Each cycle it gives the issue turn to exactly one SIMD, and the SIMDs take their turns in a fixed four-cycle rotation. On a SIMD's turn the arbiter fills each execution port from a different wavefront. A scalar ALU op, a vector ALU op, a vector memory op, a scalar memory/LDS op and a branch/message op can therefore all leave in the same cycle.

The vector port is the one exception to the one-per-class limit. When the winning vector op is an FP32 operation, a second FP32 op from another wave may be paired with it. A SIMD therefore needs at least two active waves to reach full FP32 rate. Within each class, the oldest ready wave wins. Age is measured from a per-SIMD rotating start pointer. A wave has at most one instruction pending, so order within a wave holds. A wave that is blocked is simply not ready, and the arbiter skips it.

Top module: `wvarb_issue_arbiter`

## Requirements
- R1: While reset is low, and in the first cycle after it, no port is valid and the turn indicator reads SIMD 0. Every wave slot starts not ready and every start pointer starts at 0.
- R2: Exactly one SIMD holds the turn each cycle, in the order 0, 1, 2, 3, 0, and so on. The turn is shown on `iss_simd`. Only waves of that SIMD issue in that cycle.
- R3: A decode lane write with a legal class code sets the addressed wave slot ready and stores the class, visible from the next cycle. The codes are 0 scalar ALU, 1 vector ALU, 2 vector memory, 3 scalar memory/LDS, 4 branch/message and 5 FP32 vector ALU. Codes 6 and 7 are ignored.
- R4: The issue ports are bit 0 scalar ALU, bit 1 vector ALU, bit 2 FP32 pair, bit 3 vector memory, bit 4 scalar memory/LDS and bit 5 branch/message. Port p carries its wave index in `iss_wave[p*5 +: 5]`. Each port issues at most one ready wave, so different classes co-issue from different waves, and no wave appears on two ports.
- R5: Within a class, the winner is the first ready wave found when scanning upward from the SIMD's start pointer, wrapping past 23. The pointer advances by one, modulo 24, at the end of each turn of its SIMD, and holds otherwise.
- R6: The vector ALU port takes the first ready wave of class 1 or 5. If that wave is class 5, the pair port carries the next ready class-5 wave in scan order. If the winner is class 1, or no other class-5 wave is ready, the pair port stays idle.
- R7: An issued wave's slot is not ready from the next cycle on, until decode presents the wave again. A presentation in the very cycle the wave issues is accepted.
- R8: A presentation to a wave that is already ready and is not issuing in that cycle is ignored. The pending class is kept.
- R9: No more than five ports are valid in a cycle. When all six would fire, the branch/message port is held back, and its wave stays ready for the SIMD's next turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_vld | input | 2 | Decode lane write strobes |
| dec_simd | input | 4 | SIMD index, 2 bits per lane |
| dec_wave | input | 10 | Wave slot index, 5 bits per lane |
| dec_type | input | 6 | Class code, 3 bits per lane |
| iss_simd | output | 2 | SIMD holding the turn this cycle |
| iss_vld | output | 6 | Per-port issue valid |
| iss_wave | output | 30 | Per-port wave index, 5 bits per port |

## Verification
A stale ready flag shows up at the ports on the SIMD's next turn, at most four cycles later. It appears as a wave issuing twice, or as a presented wave that never issues. A start pointer that is off by one shows up on the first turn where two waves of one class are ready, because the wrong wave index is issued. A pairing fault shows up in the same turn as a pair port that fires after a plain vector winner, or that stays idle while two FP32 waves wait. The bench keeps its own copy of every slot and pointer, and it predicts all six ports on every turn, so any such divergence is reported within one rotation.

// File: rtl/wvarb_pkg.sv
// Shared types for the wavefront issue arbiter: class codes, port map
// and the per-cycle issue cap.
package wvarb_pkg;

    typedef enum logic [2:0] {
        OP_SALU  = 3'd0,
        OP_VALU  = 3'd1,
        OP_VMEM  = 3'd2,
        OP_SMEM  = 3'd3,
        OP_BRMSG = 3'd4,
        OP_VF32  = 3'd5
    } op_t;

    localparam int NUM_PORTS  = 6;
    localparam int P_SALU     = 0;
    localparam int P_VALU     = 1;
    localparam int P_VPAIR    = 2;
    localparam int P_VMEM     = 3;
    localparam int P_SMEM     = 4;
    localparam int P_BR       = 5;
    localparam int NUM_SINGLE = 4;
    localparam int ISSUE_CAP  = 5;

    // True for class codes that decode may legally present.
    function automatic logic op_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    // Class served by single-issue port group g.
    function automatic op_t single_code(input int g);
        case (g)
            0:       return OP_SALU;
            1:       return OP_VMEM;
            2:       return OP_SMEM;
            default: return OP_BRMSG;
        endcase
    endfunction

    // Port index driven by single-issue port group g.
    function automatic int single_port(input int g);
        case (g)
            0:       return P_SALU;
            1:       return P_VMEM;
            2:       return P_SMEM;
            default: return P_BR;
        endcase
    endfunction

endpackage

// File: rtl/wvarb_oldest_pick.sv
// Oldest-first picker: returns the first set candidate bit found when
// scanning upward from a start position with wrap-around.
// Assumes start < N.
module wvarb_oldest_pick #(
    parameter int  N = 24,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] cand,
    input  logic [W-1:0] start,
    output logic         found,
    output logic [W-1:0] pick
);

    // Scan from the farthest position back to start so the nearest hit wins.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int pos;
            pos = int'(start) + k;
            if (pos >= N) pos = pos - N;
            if (cand[pos]) begin
                found = 1'b1;
                pick  = W'(pos);
            end
        end
    end

endmodule

// File: rtl/wvarb_slot_table.sv
// Wave slot table: one ready flag and one class tag per wave per SIMD.
// Decode lanes set slots, and issue clears them for the SIMD holding the
// turn. Assumes the clear mask refers to look_simd. Lane 0 has priority
// when two lanes hit the same slot.
module wvarb_slot_table
    import wvarb_pkg::*;
#(
    parameter int  NUM_SIMD  = 4,
    parameter int  NUM_WAVES = 24,
    parameter int  DEC_LANES = 2,
    localparam int SW = $clog2(NUM_SIMD),
    localparam int WW = $clog2(NUM_WAVES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEC_LANES-1:0]    dec_vld,
    input  logic [DEC_LANES*SW-1:0] dec_simd,
    input  logic [DEC_LANES*WW-1:0] dec_wave,
    input  logic [DEC_LANES*3-1:0]  dec_type,
    input  logic [SW-1:0]           look_simd,
    input  logic [NUM_WAVES-1:0]    clr_mask,
    output logic [NUM_WAVES-1:0]    look_rdy,
    output op_t                     look_op [NUM_WAVES]
);

    logic rdy_q [NUM_SIMD][NUM_WAVES];
    op_t  op_q  [NUM_SIMD][NUM_WAVES];
    logic hit   [NUM_SIMD][NUM_WAVES];
    op_t  hop   [NUM_SIMD][NUM_WAVES];
    logic clr   [NUM_SIMD][NUM_WAVES];

    // Decode lanes addressing each slot with a legal class; lane 0 wins.
    always_comb begin
        for (int s = 0; s < NUM_SIMD; s++) begin
            for (int w = 0; w < NUM_WAVES; w++) begin
                hit[s][w] = 1'b0;
                hop[s][w] = OP_SALU;
                clr[s][w] = (look_simd == SW'(s)) && clr_mask[w];
                for (int l = DEC_LANES - 1; l >= 0; l--) begin
                    if (dec_vld[l] && dec_simd[l*SW +: SW] == SW'(s) &&
                        dec_wave[l*WW +: WW] == WW'(w) &&
                        op_legal(dec_type[l*3 +: 3])) begin
                        hit[s][w] = 1'b1;
                        hop[s][w] = op_t'(dec_type[l*3 +: 3]);
                    end
                end
            end
        end
    end

    // Slot update: accept a new instruction only into a free or issuing slot.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SIMD; s++) begin
            for (int w = 0; w < NUM_WAVES; w++) begin
                if (!rst_n) begin
                    rdy_q[s][w] <= 1'b0;
                    op_q[s][w]  <= OP_SALU;
                end else if (hit[s][w] && (!rdy_q[s][w] || clr[s][w])) begin
                    rdy_q[s][w] <= 1'b1;
                    op_q[s][w]  <= hop[s][w];
                end else if (clr[s][w]) begin
                    rdy_q[s][w] <= 1'b0;
                end
            end
        end
    end

    // Present the slots of the SIMD that holds the turn.
    always_comb begin
        for (int w = 0; w < NUM_WAVES; w++) begin
            look_rdy[w] = rdy_q[look_simd][w];
            look_op[w]  = op_q[look_simd][w];
        end
    end

    for (genvar gs = 0; gs < NUM_SIMD; gs++) begin : g_chk_simd
        for (genvar gw = 0; gw < NUM_WAVES; gw++) begin : g_chk_wave
            AST_CLEAR_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
                clr[gs][gw] && !hit[gs][gw] |=> !rdy_q[gs][gw]); // R7
            AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                rdy_q[gs][gw] && !clr[gs][gw] |=> rdy_q[gs][gw] && $stable(op_q[gs][gw])); // R8
        end
    end

endmodule

// File: rtl/wvarb_port_select.sv
// Port selection for the SIMD holding the turn. It picks the oldest ready
// wave per class, pairs a second FP32 wave behind an FP32 vector winner,
// and holds back the branch port when six ports would fire.
// Assumes start < NUM_WAVES.
module wvarb_port_select
    import wvarb_pkg::*;
#(
    parameter int  NUM_WAVES = 24,
    localparam int WW = $clog2(NUM_WAVES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WAVES-1:0] wave_rdy,
    input  op_t                  wave_op [NUM_WAVES],
    input  logic [WW-1:0]        start,
    output logic [NUM_PORTS-1:0] port_vld,
    output logic [WW-1:0]        port_wave [NUM_PORTS]
);

    logic [NUM_SINGLE-1:0] s_found;
    logic [WW-1:0]         s_pick [NUM_SINGLE];
    logic [NUM_WAVES-1:0]  valu_mask;
    logic [NUM_WAVES-1:0]  pair_mask;
    logic                  prim_found;
    logic [WW-1:0]         prim_pick;
    logic                  pair_found;
    logic [WW-1:0]         pair_pick;
    logic                  prim_f32;
    logic                  pair_ok;
    logic [NUM_PORTS-1:0]  req;

    for (genvar g = 0; g < NUM_SINGLE; g++) begin : g_single
        logic [NUM_WAVES-1:0] m;
        // Ready waves of this port's class.
        always_comb begin
            for (int w = 0; w < NUM_WAVES; w++)
                m[w] = wave_rdy[w] && (wave_op[w] == single_code(g));
        end
        wvarb_oldest_pick #(.N(NUM_WAVES)) u_pick (
            .cand  (m),
            .start (start),
            .found (s_found[g]),
            .pick  (s_pick[g])
        );
    end

    // Vector candidates of either kind, and FP32 partners other than the winner.
    always_comb begin
        for (int w = 0; w < NUM_WAVES; w++) begin
            valu_mask[w] = wave_rdy[w] && (wave_op[w] == OP_VALU || wave_op[w] == OP_VF32);
            pair_mask[w] = wave_rdy[w] && (wave_op[w] == OP_VF32) && (prim_pick != WW'(w));
        end
    end

    wvarb_oldest_pick #(.N(NUM_WAVES)) u_prim (
        .cand  (valu_mask),
        .start (start),
        .found (prim_found),
        .pick  (prim_pick)
    );

    wvarb_oldest_pick #(.N(NUM_WAVES)) u_pair (
        .cand  (pair_mask),
        .start (start),
        .found (pair_found),
        .pick  (pair_pick)
    );

    // Pairing applies only behind an FP32 vector winner.
    always_comb begin
        prim_f32 = wave_op[prim_pick] == OP_VF32;
        pair_ok  = prim_found && prim_f32 && pair_found;
    end

    // Assemble port valids and wave indices, then apply the issue cap.
    always_comb begin
        req = '0;
        for (int p = 0; p < NUM_PORTS; p++) port_wave[p] = '0;
        for (int g = 0; g < NUM_SINGLE; g++) begin
            req[single_port(g)]       = s_found[g];
            port_wave[single_port(g)] = s_pick[g];
        end
        req[P_VALU]        = prim_found;
        port_wave[P_VALU]  = prim_pick;
        req[P_VPAIR]       = pair_ok;
        port_wave[P_VPAIR] = pair_pick;
        port_vld = req;
        if ($countones(req) > ISSUE_CAP) port_vld[P_BR] = 1'b0;
    end

    AST_PAIR_BOTH_F32: assert property (@(posedge clk) disable iff (!rst_n)
        port_vld[P_VPAIR] |-> port_vld[P_VALU] && wave_op[port_wave[P_VALU]] == OP_VF32
                              && wave_op[port_wave[P_VPAIR]] == OP_VF32); // R6
    AST_PAIR_TWO_WAVES: assert property (@(posedge clk) disable iff (!rst_n)
        port_vld[P_VPAIR] |-> port_wave[P_VPAIR] != port_wave[P_VALU]); // R6
    AST_ISSUE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(port_vld) <= ISSUE_CAP); // R9

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_chk_port
        AST_PORT_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
            port_vld[gp] |-> wave_rdy[port_wave[gp]]); // R4
    end

endmodule

// File: rtl/wvarb_issue_arbiter.sv
// Wavefront issue arbiter, top level. It rotates the issue turn over the
// SIMDs, keeps one start pointer per SIMD, and drives the execution ports
// from the slot table of the SIMD holding the turn.
// Assumes decode never presents a wave index >= NUM_WAVES.
module wvarb_issue_arbiter
    import wvarb_pkg::*;
#(
    parameter int  NUM_SIMD  = 4,
    parameter int  NUM_WAVES = 24,
    parameter int  DEC_LANES = 2,
    localparam int SW = $clog2(NUM_SIMD),
    localparam int WW = $clog2(NUM_WAVES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEC_LANES-1:0]    dec_vld,
    input  logic [DEC_LANES*SW-1:0] dec_simd,
    input  logic [DEC_LANES*WW-1:0] dec_wave,
    input  logic [DEC_LANES*3-1:0]  dec_type,
    output logic [SW-1:0]           iss_simd,
    output logic [NUM_PORTS-1:0]    iss_vld,
    output logic [NUM_PORTS*WW-1:0] iss_wave
);

    logic [SW-1:0]        sel_q;
    logic [WW-1:0]        ptr_q [NUM_SIMD];
    logic [NUM_WAVES-1:0] look_rdy;
    op_t                  look_op [NUM_WAVES];
    logic [NUM_WAVES-1:0] clr_mask;
    logic [NUM_PORTS-1:0] port_vld;
    logic [WW-1:0]        port_wave [NUM_PORTS];
    logic                 dup_wave;

    // Issue turn rotation over the SIMDs.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sel_q <= '0;
        else if (sel_q == SW'(NUM_SIMD - 1)) sel_q <= '0;
        else                                 sel_q <= sel_q + SW'(1);
    end

    for (genvar s = 0; s < NUM_SIMD; s++) begin : g_ptr
        // Start pointer steps at the end of its own SIMD's turn.
        always_ff @(posedge clk) begin
            if (!rst_n)                          ptr_q[s] <= '0;
            else if (sel_q == SW'(s)) begin
                if (ptr_q[s] == WW'(NUM_WAVES - 1)) ptr_q[s] <= '0;
                else                                ptr_q[s] <= ptr_q[s] + WW'(1);
            end
        end
        AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
            sel_q != SW'(s) |=> $stable(ptr_q[s])); // R5
    end

    wvarb_slot_table #(
        .NUM_SIMD  (NUM_SIMD),
        .NUM_WAVES (NUM_WAVES),
        .DEC_LANES (DEC_LANES)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_vld   (dec_vld),
        .dec_simd  (dec_simd),
        .dec_wave  (dec_wave),
        .dec_type  (dec_type),
        .look_simd (sel_q),
        .clr_mask  (clr_mask),
        .look_rdy  (look_rdy),
        .look_op   (look_op)
    );

    wvarb_port_select #(.NUM_WAVES(NUM_WAVES)) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .wave_rdy  (look_rdy),
        .wave_op   (look_op),
        .start     (ptr_q[sel_q]),
        .port_vld  (port_vld),
        .port_wave (port_wave)
    );

    // Issued waves release their slots, and ports are flattened.
    always_comb begin
        clr_mask = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_vld[p]) clr_mask[port_wave[p]] = 1'b1;
            iss_wave[p*WW +: WW] = port_wave[p];
        end
        iss_vld  = port_vld;
        iss_simd = sel_q;
    end

    // Checker: flags one wave driven on two ports in the same cycle.
    always_comb begin
        dup_wave = 1'b0;
        for (int a = 0; a < NUM_PORTS; a++)
            for (int b = a + 1; b < NUM_PORTS; b++)
                if (port_vld[a] && port_vld[b] && port_wave[a] == port_wave[b])
                    dup_wave = 1'b1;
    end

    AST_DISTINCT_WAVES: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_wave); // R4
    AST_ROTATE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sel_q == (($past(sel_q) == SW'(NUM_SIMD - 1)) ? SW'(0)
                                   : $past(sel_q) + SW'(1))); // R2

endmodule

// File: tb/wvarb_issue_arbiter_tb.sv
module wvarb_issue_arbiter_tb;

    localparam int NS = 4;
    localparam int NW = 24;
    localparam int NP = 6;
    localparam int C_SALU = 0, C_VALU = 1, C_VMEM = 2, C_SMEM = 3, C_BR = 4, C_F32 = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  dec_vld;
    logic [3:0]  dec_simd;
    logic [9:0]  dec_wave;
    logic [5:0]  dec_type;
    logic [1:0]  iss_simd;
    logic [5:0]  iss_vld;
    logic [29:0] iss_wave;

    int n_chk = 0;
    int n_fail = 0;
    bit model_on = 0;
    bit rdy_m [NS][NW];
    int typ_m [NS][NW];
    int ptr_m [NS];
    int turn_m = 0;
    logic [5:0] got_vld [NS];
    int got_w [NS][NP];
    int p;

    always #10 clk = ~clk;

    wvarb_issue_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_simd(dec_simd),
        .dec_wave(dec_wave), .dec_type(dec_type), .iss_simd(iss_simd),
        .iss_vld(iss_vld), .iss_wave(iss_wave)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // First ready wave of a class in scan order; class 9 means either vector kind.
    function automatic int first_of(input int s, input int cls, input int excl);
        for (int k = 0; k < NW; k++) begin
            int w;
            w = (ptr_m[s] + k) % NW;
            if (rdy_m[s][w] && w != excl &&
                (cls == 9 ? (typ_m[s][w] == C_VALU || typ_m[s][w] == C_F32) : typ_m[s][w] == cls))
                return w;
        end
        return -1;
    endfunction

    // Reference model: predicts every turn from the requirements, then updates.
    always @(negedge clk) begin
        if (model_on) begin
            int t;
            int ew [NP];
            logic [5:0] ev;
            int bad;
            t = turn_m;
            chk(iss_simd == 2'(t), "R2 turn order", iss_simd, t);
            ew[0] = first_of(t, C_SALU, -1);
            ew[1] = first_of(t, 9, -1);
            ew[2] = (ew[1] >= 0 && typ_m[t][ew[1] < 0 ? 0 : ew[1]] == C_F32) ? first_of(t, C_F32, ew[1]) : -1;
            ew[3] = first_of(t, C_VMEM, -1);
            ew[4] = first_of(t, C_SMEM, -1);
            ew[5] = first_of(t, C_BR, -1);
            for (int q = 0; q < NP; q++) ev[q] = ew[q] >= 0;
            if ($countones(ev) > 5) ev[5] = 1'b0;
            chk(iss_vld == ev, "R5 model port valids", iss_vld, ev);
            bad = -1;
            for (int q = 0; q < NP; q++) begin
                got_w[t][q] = int'(iss_wave[q*5 +: 5]);
                if (ev[q] && got_w[t][q] != ew[q] && bad < 0) bad = q;
            end
            got_vld[t] = iss_vld;
            chk(bad < 0, "R5 model wave index", bad < 0 ? 0 : got_w[t][bad], bad < 0 ? 0 : ew[bad]);
            for (int q = 0; q < NP; q++) if (ev[q]) rdy_m[t][ew[q]] = 0;
            ptr_m[t] = (ptr_m[t] + 1) % NW;
            turn_m = (turn_m + 1) % NS;
            for (int l = 1; l >= 0; l--) begin
                int s, w, c;
                s = int'(dec_simd[l*2 +: 2]);
                w = int'(dec_wave[l*5 +: 5]);
                c = int'(dec_type[l*3 +: 3]);
                if (dec_vld[l] && c <= 5 && w < NW && !rdy_m[s][w]) begin
                    rdy_m[s][w] = 1;
                    typ_m[s][w] = c;
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic reach_turn(input int s);
        while (iss_simd != 2'(s)) step();
    endtask

    task automatic goto_turn(input int s);
        step();
        reach_turn(s);
    endtask

    task automatic put2(input int s, input int w0, input int t0, input int w1, input int t1, input bit two);
        dec_vld  = {two, 1'b1};
        dec_simd = {2'(s), 2'(s)};
        dec_wave = {5'(w1), 5'(w0)};
        dec_type = {3'(t1), 3'(t0)};
        step();
        dec_vld = '0;
    endtask

    function automatic int wv(input int k);
        return (p + k) % NW;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        dec_vld = '0; dec_simd = '0; dec_wave = '0; dec_type = '0;
        repeat (3) step();
        chk(iss_vld == 6'd0, "R1 no issue in reset", iss_vld, 0);
        chk(iss_simd == 2'd0, "R1 turn at SIMD 0", iss_simd, 0);
        rst_n = 1'b1;
        model_on = 1;
    endtask

    task automatic t_coissue();
        goto_turn(1);
        p = (ptr_m[1] + 1) % NW;
        put2(1, wv(3), C_SALU, wv(5), C_VALU, 1);
        put2(1, wv(1), C_VMEM, wv(7), C_SMEM, 1);
        put2(1, wv(2), C_BR, 0, 0, 0);
        reach_turn(1);
        step();
        chk(got_vld[1] == 6'b111011, "R4 five classes co-issue", got_vld[1], 6'b111011);
        chk(got_w[1][0] == wv(3) && got_w[1][1] == wv(5), "R4 scalar with vector ALU", got_w[1][0], wv(3));
        chk(got_w[1][3] == wv(1) && got_w[1][4] == wv(7) && got_w[1][5] == wv(2),
            "R3 class routing", got_w[1][3], wv(1));
    endtask

    task automatic t_oldest();
        goto_turn(2);
        p = (ptr_m[2] + 1) % NW;
        put2(2, wv(9), C_VMEM, wv(4), C_VMEM, 1);
        put2(2, wv(20), C_VMEM, wv(23), C_VMEM, 1);
        reach_turn(2);
        step();
        chk(got_vld[2][3] && got_w[2][3] == wv(4), "R5 nearest to pointer wins", got_w[2][3], wv(4));
        goto_turn(2);
        step();
        chk(got_vld[2][3] && got_w[2][3] == wv(9), "R5 pointer advanced", got_w[2][3], wv(9));
        goto_turn(2);
        goto_turn(2);
    endtask

    task automatic t_pair();
        goto_turn(3);
        p = (ptr_m[3] + 1) % NW;
        put2(3, wv(2), C_F32, wv(6), C_F32, 1);
        put2(3, wv(10), C_F32, 0, 0, 0);
        reach_turn(3);
        step();
        chk(got_vld[3][1] && got_w[3][1] == wv(2), "R6 FP32 primary", got_w[3][1], wv(2));
        chk(got_vld[3][2] && got_w[3][2] == wv(6), "R6 FP32 partner", got_w[3][2], wv(6));
        goto_turn(3);
        step();
        chk(got_vld[3][1] && !got_vld[3][2], "R6 lone FP32 not paired", got_vld[3], 6'b000010);
        goto_turn(3);
        p = (ptr_m[3] + 1) % NW;
        put2(3, wv(1), C_VALU, wv(3), C_F32, 1);
        reach_turn(3);
        step();
        chk(got_w[3][1] == wv(1) && !got_vld[3][2], "R6 plain winner blocks pair", got_vld[3], 6'b000010);
        goto_turn(3);
    endtask

    task automatic t_clear();
        goto_turn(0);
        put2(0, 7, C_SALU, 0, 0, 0);
        reach_turn(0);
        put2(0, 7, C_VMEM, 0, 0, 0);
        chk(got_vld[0][0] && got_w[0][0] == 7, "R7 wave issues", got_w[0][0], 7);
        reach_turn(0);
        step();
        chk(got_vld[0] == 6'b001000 && got_w[0][3] == 7, "R7 same-cycle re-present", got_vld[0], 6'b001000);
        reach_turn(0);
        step();
        chk(got_vld[0] == 6'd0, "R7 no repeat issue", got_vld[0], 0);
    endtask

    task automatic t_ignore();
        goto_turn(1);
        put2(1, 4, C_SALU, 9, 6, 1);
        put2(1, 4, C_VMEM, 0, 0, 0);
        reach_turn(1);
        step();
        chk(got_vld[1] == 6'b000001 && got_w[1][0] == 4, "R8 pending class kept", got_vld[1], 1);
        chk(got_vld[1][3] == 1'b0, "R3 code 6 ignored", got_vld[1], 1);
        reach_turn(1);
        step();
        chk(got_vld[1] == 6'd0, "R8 second present dropped", got_vld[1], 0);
    endtask

    task automatic t_cap();
        goto_turn(2);
        p = (ptr_m[2] + 1) % NW;
        put2(2, wv(1), C_F32, wv(2), C_F32, 1);
        put2(2, wv(3), C_SALU, wv(4), C_VMEM, 1);
        put2(2, wv(5), C_SMEM, wv(6), C_BR, 1);
        reach_turn(2);
        step();
        chk(got_vld[2] == 6'b011111, "R9 branch held at cap", got_vld[2], 6'b011111);
        reach_turn(2);
        step();
        chk(got_vld[2] == 6'b100000 && got_w[2][5] == wv(6), "R9 held branch issues next turn",
            got_w[2][5], wv(6));
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            ptr_m[s] = 0;
            for (int w = 0; w < NW; w++) begin rdy_m[s][w] = 0; typ_m[s][w] = 0; end
        end
        t_reset();
        t_coissue();
        t_oldest();
        t_pair();
        t_clear();
        t_ignore();
        t_cap();
        repeat (8) step();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule